// File: doc/BRIEF.md
# Neumann Series Matrix Inverse

This block approximates the inverse of a small, square, real matrix whose diagonal dominates each row. All values are two's-complement fixed point with a configurable number of fraction bits. The matrix is split into two parts: its main diagonal, and the rest of the matrix with zeros on the diagonal. The reciprocals of the diagonal entries form the first estimate. The block then repeatedly multiplies a running term matrix by the fixed step matrix M = −D⁻¹·Aoff and adds each new term into a saturating sum. No elimination and no factorization is used.

The host streams the K×K matrix in, one element per cycle, in row-major order. It then pulses `start` together with the number of extra series terms. The block computes one reciprocal per diagonal entry with a serial divider, builds M, and runs the term loop on a single shared multiply-accumulate unit. When the loop ends it pulses `done` and streams the K·K result entries out with `out_valid`.

Top module: `nsi_inverse`

## Requirements
- R1: While idle, each cycle with `load_valid` high writes `load_data` into the matrix store at a write pointer, in row-major order (index = row·K + column). The pointer wraps from K·K−1 back to 0, so extra elements overwrite from the first entry. An accepted `start` clears the pointer to 0. When `start` and `load_valid` are high in the same cycle, the load is dropped.
- R2: Each diagonal entry a gives the reciprocal r = sign(a)·min(floor(2^(2·FRAC)/|a|), 2^(W−1)−1). The value −2^(W−1) is a valid input.
- R3: A zero diagonal entry gives a reciprocal of 0 and sets `div_err`. `div_err` is cleared only by the next accepted `start`, and it stays unchanged while the block is idle.
- R4: With `n_terms` = 0, the result is the seed alone: the reciprocals on the diagonal and zeros everywhere else.
- R5: The step matrix has M[i][i] = 0 and, off the diagonal, M[i][j] = sat((−r_i·A[i][j]) >>> FRAC). Each of the `n_terms` iterations forms T'[i][j] = sat((Σ_k M[i][k]·T[k][j]) >>> FRAC), summing full-precision products before a single arithmetic (floor) shift.
- R6: The sum starts equal to the seed and adds each new term element by element. Every addition saturates to the range −2^(W−1) to 2^(W−1)−1 and never wraps.
- R7: After the last term, `done` is high for exactly one cycle. On the following K·K cycles `out_valid` is high and `out_data` presents the result in row-major order. Then `out_valid` falls.
- R8: While `busy` is high, `start` and `load_valid` are ignored. A later run without reloading uses the unchanged matrix.
- R9: `busy` rises in the cycle after an accepted `start` and stays high until the last output beat, after which it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Matrix element present on `load_data` |
| load_data | input | W | Matrix element, signed fixed point |
| start | input | 1 | Begin a computation (accepted only when idle) |
| n_terms | input | TW | Number of series terms after the seed |
| busy | output | 1 | Computation or readout in progress |
| done | output | 1 | One-cycle pulse after the last term |
| div_err | output | 1 | A zero diagonal entry was met in the last run |
| out_valid | output | 1 | Result element present on `out_data` |
| out_data | output | W | Result element, row-major |

## Verification
The bound checker watches the handshake on every cycle:
- `done` lasts exactly one cycle and is followed at once by output beats.
- `out_valid` and `done` only appear while `busy` is high.
- An idle `start` leads to a busy cycle without output.
- The readout stops after exactly K·K beats.
- `div_err` cannot change while the block is idle.

The arithmetic content can only be shown by the bench scenarios, which compare each streamed value against a bench model. These scenarios cover:
- reciprocal saturation and the most negative diagonal value;
- zero diagonals;
- saturating sums;
- load-pointer wrap;
- a zero term count;
- stimulus injected while busy.

// File: rtl/nsi_pkg.sv
package nsi_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_DIV  = 3'd1,
        PH_MBLD = 3'd2,
        PH_MAC  = 3'd3,
        PH_DONE = 3'd4,
        PH_OUT  = 3'd5
    } nsi_phase_e;

endpackage

// File: rtl/nsi_recip.sv
// Serial restoring divider: q = sign(den) * min(2^(2F) / |den|, 2^(W-1)-1)
module nsi_recip #(
    parameter int W    = 16,
    parameter int FRAC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic signed [W-1:0] den,
    output logic                rdy,
    output logic signed [W-1:0] q,
    output logic                zero
);
    localparam int NW = 2 * FRAC + 1;
    localparam int CW = $clog2(NW + 1);
    localparam logic [NW-1:0] QMAX = NW'((longint'(1) << (W - 1)) - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [NW-1:0] num;
        logic [W-1:0]  rem;
        logic [W-1:0]  mag;
        logic          neg;
        logic [NW-1:0] quo;
        logic          zero;
        logic          rdy;
        logic [W-1:0]  q;
    } rcp_t;

    rcp_t r_q, r_d;

    always_comb begin
        logic [W-1:0]  trial;
        logic [NW-1:0] qn;
        logic [NW-1:0] qs;
        r_d     = r_q;
        r_d.rdy = 1'b0;
        trial   = '0;
        qn      = '0;
        qs      = '0;
        if (go && !r_q.run) begin
            r_d.run  = 1'b1;
            r_d.cnt  = '0;
            r_d.num  = NW'(1) << (NW - 1);
            r_d.rem  = '0;
            r_d.neg  = den[W-1];
            r_d.mag  = den[W-1] ? (~den + W'(1)) : den;
            r_d.quo  = '0;
            r_d.zero = (den == '0);
        end else if (r_q.run) begin
            trial   = {r_q.rem[W-2:0], r_q.num[NW-1]};
            r_d.num = r_q.num << 1;
            if (trial >= r_q.mag) begin
                r_d.rem = trial - r_q.mag;
                qn      = {r_q.quo[NW-2:0], 1'b1};
            end else begin
                r_d.rem = trial;
                qn      = {r_q.quo[NW-2:0], 1'b0};
            end
            r_d.quo = qn;
            r_d.cnt = r_q.cnt + CW'(1);
            if (r_q.cnt == CW'(NW - 1)) begin
                qs      = (qn > QMAX) ? QMAX : qn;
                r_d.q   = r_q.neg ? (~qs[W-1:0] + W'(1)) : qs[W-1:0];
                r_d.rdy = 1'b1;
                r_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdy  = r_q.rdy;
    assign q    = r_q.q;
    assign zero = r_q.zero;

endmodule

// File: rtl/nsi_mac.sv
// Shared multiply-accumulate with a floor shift and a saturating narrow result
module nsi_mac #(
    parameter int W    = 16,
    parameter int FRAC = 8,
    parameter int ACCW = 35
) (
    input  logic signed [ACCW-1:0] acc_in,
    input  logic signed [W-1:0]    op_a,
    input  logic signed [W-1:0]    op_b,
    output logic signed [ACCW-1:0] acc_out,
    output logic signed [W-1:0]    res
);
    localparam logic signed [ACCW-1:0] VMAX = ACCW'((longint'(1) << (W - 1)) - 1);
    localparam logic signed [ACCW-1:0] VMIN = -VMAX - ACCW'(1);

    logic signed [2*W-1:0]  prod;
    logic signed [ACCW-1:0] pext;
    logic signed [ACCW-1:0] shifted;

    always_comb begin
        prod    = op_a * op_b;
        pext    = {{(ACCW - 2 * W){prod[2*W-1]}}, prod};
        acc_out = acc_in + pext;
        shifted = acc_out >>> FRAC;
        if (shifted > VMAX)      res = VMAX[W-1:0];
        else if (shifted < VMIN) res = VMIN[W-1:0];
        else                     res = shifted[W-1:0];
    end

endmodule

// File: rtl/nsi_sat_add.sv
module nsi_sat_add #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] x,
    input  logic signed [W-1:0] y,
    output logic signed [W-1:0] s
);
    logic [W:0] wide;

    always_comb begin
        wide = {x[W-1], x} + {y[W-1], y};
        if (wide[W] != wide[W-1]) s = wide[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else                      s = wide[W-1:0];
    end

endmodule

// File: rtl/nsi_inverse.sv
module nsi_inverse #(
    parameter int K    = 4,
    parameter int W    = 16,
    parameter int FRAC = 8,
    parameter int TW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_valid,
    input  logic [W-1:0]  load_data,
    input  logic          start,
    input  logic [TW-1:0] n_terms,
    output logic          busy,
    output logic          done,
    output logic          div_err,
    output logic          out_valid,
    output logic [W-1:0]  out_data
);
    import nsi_pkg::*;

    localparam int NE   = K * K;
    localparam int IW   = $clog2(NE);
    localparam int KW   = $clog2(K);
    localparam int ACCW = 2 * W + KW + 1;

    typedef struct packed {
        nsi_phase_e             st;
        logic [IW-1:0]          wptr;
        logic [TW-1:0]          nterm;
        logic [TW-1:0]          term;
        logic [NE-1:0][W-1:0]   a;
        logic [NE-1:0][W-1:0]   m;
        logic [NE-1:0][W-1:0]   t;
        logic [NE-1:0][W-1:0]   s;
        logic [K-1:0][W-1:0]    col;
        logic [K-1:0][W-1:0]    dinv;
        logic                   err;
        logic [KW-1:0]          di;
        logic                   dgo;
        logic [KW-1:0]          ii;
        logic [KW-1:0]          jj;
        logic [KW-1:0]          kk;
        logic signed [ACCW-1:0] acc;
        logic [IW-1:0]          ri;
    } core_t;

    core_t q, d;

    // shared arithmetic
    logic signed [ACCW-1:0] mac_acc, mac_sum;
    logic signed [W-1:0]    mac_a, mac_b, mac_res;
    logic signed [W-1:0]    add_x, add_s;
    logic                   rcp_rdy, rcp_zero;
    logic signed [W-1:0]    rcp_q;
    logic [IW-1:0]          ix_ij, ix_ik, ix_kj, ix_dd;

    nsi_recip #(.W(W), .FRAC(FRAC)) u_recip (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (q.dgo),
        .den  (q.a[ix_dd]),
        .rdy  (rcp_rdy),
        .q    (rcp_q),
        .zero (rcp_zero)
    );

    nsi_mac #(.W(W), .FRAC(FRAC), .ACCW(ACCW)) u_mac (
        .acc_in (mac_acc),
        .op_a   (mac_a),
        .op_b   (mac_b),
        .acc_out(mac_sum),
        .res    (mac_res)
    );

    nsi_sat_add #(.W(W)) u_add (
        .x(add_x),
        .y(mac_res),
        .s(add_s)
    );

    // operand selection, driven from registered state only
    always_comb begin
        ix_ij   = IW'(int'(q.ii) * K + int'(q.jj));
        ix_ik   = IW'(int'(q.ii) * K + int'(q.kk));
        ix_kj   = IW'(int'(q.kk) * K + int'(q.jj));
        ix_dd   = IW'(int'(q.di) * K + int'(q.di));
        mac_acc = '0;
        mac_a   = '0;
        mac_b   = '0;
        if (q.st == PH_MBLD) begin
            mac_a = -$signed(q.dinv[q.ii]);
            mac_b = q.a[ix_ij];
        end else if (q.st == PH_MAC) begin
            mac_acc = q.acc;
            mac_a   = q.m[ix_ik];
            mac_b   = q.t[ix_kj];
        end
        add_x = q.s[ix_ij];
    end

    always_comb begin
        d     = q;
        d.dgo = 1'b0;
        unique case (q.st)
            PH_IDLE: begin
                if (start) begin
                    d.st    = PH_DIV;
                    d.nterm = n_terms;
                    d.err   = 1'b0;
                    d.wptr  = '0;
                    d.di    = '0;
                    d.dgo   = 1'b1;
                end else if (load_valid) begin
                    d.a[q.wptr] = load_data;
                    d.wptr      = (q.wptr == IW'(NE - 1)) ? '0 : q.wptr + IW'(1);
                end
            end
            PH_DIV: begin
                if (rcp_rdy) begin
                    d.dinv[q.di] = rcp_zero ? '0 : rcp_q;
                    d.err        = q.err | rcp_zero;
                    if (q.di == KW'(K - 1)) begin
                        d.st = PH_MBLD;
                        d.ii = '0;
                        d.jj = '0;
                    end else begin
                        d.di  = q.di + KW'(1);
                        d.dgo = 1'b1;
                    end
                end
            end
            PH_MBLD: begin
                if (q.ii == q.jj) begin
                    d.m[ix_ij] = '0;
                    d.t[ix_ij] = q.dinv[q.ii];
                    d.s[ix_ij] = q.dinv[q.ii];
                end else begin
                    d.m[ix_ij] = mac_res;
                    d.t[ix_ij] = '0;
                    d.s[ix_ij] = '0;
                end
                if (q.jj == KW'(K - 1)) begin
                    d.jj = '0;
                    if (q.ii == KW'(K - 1)) begin
                        d.ii   = '0;
                        d.kk   = '0;
                        d.acc  = '0;
                        d.term = '0;
                        d.st   = (q.nterm == '0) ? PH_DONE : PH_MAC;
                    end else begin
                        d.ii = q.ii + KW'(1);
                    end
                end else begin
                    d.jj = q.jj + KW'(1);
                end
            end
            PH_MAC: begin
                if (q.kk != KW'(K - 1)) begin
                    d.acc = mac_sum;
                    d.kk  = q.kk + KW'(1);
                end else begin
                    d.acc        = '0;
                    d.kk         = '0;
                    d.col[q.ii]  = mac_res;
                    d.s[ix_ij]   = add_s;
                    if (q.ii == KW'(K - 1)) begin
                        for (int r = 0; r < K; r++) begin
                            d.t[IW'(r * K) + IW'(q.jj)] = (r == K - 1) ? mac_res : q.col[r];
                        end
                        d.ii = '0;
                        if (q.jj == KW'(K - 1)) begin
                            d.jj   = '0;
                            d.term = q.term + TW'(1);
                            if (q.term + TW'(1) == q.nterm) d.st = PH_DONE;
                        end else begin
                            d.jj = q.jj + KW'(1);
                        end
                    end else begin
                        d.ii = q.ii + KW'(1);
                    end
                end
            end
            PH_DONE: begin
                d.st = PH_OUT;
                d.ri = '0;
            end
            PH_OUT: begin
                if (q.ri == IW'(NE - 1)) d.st = PH_IDLE;
                else                     d.ri = q.ri + IW'(1);
            end
            default: d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != PH_IDLE);
    assign done      = (q.st == PH_DONE);
    assign out_valid = (q.st == PH_OUT);
    assign out_data  = q.s[q.ri];
    assign div_err   = q.err;

endmodule

// File: rtl/nsi_inverse_chk.sv
module nsi_inverse_chk #(
    parameter int NE = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic div_err,
    input logic out_valid
);
    int beats;

    always_ff @(posedge clk) begin
        if (!rst_n)         beats <= 0;
        else if (done)      beats <= 0;
        else if (out_valid) beats <= beats + 1;
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_then_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> out_valid);

    p_beat_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (beats == NE));

    p_out_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || done) |-> busy);

    p_start_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !out_valid && !done));

    p_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(div_err));

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && out_valid));

endmodule

bind nsi_inverse nsi_inverse_chk #(.NE(K * K)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .div_err  (div_err),
    .out_valid(out_valid)
);

// File: tb/sim_nsi_inverse.sv
module sim_nsi_inverse;
    localparam int K    = 4;
    localparam int W    = 16;
    localparam int FRAC = 8;
    localparam int TW   = 4;
    localparam int NE   = K * K;
    localparam longint VMAX = 32767;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_valid = 1'b0;
    logic [W-1:0]  load_data = '0;
    logic          start = 1'b0;
    logic [TW-1:0] n_terms = '0;
    logic          busy, done, div_err, out_valid;
    logic [W-1:0]  out_data;

    always #4 clk = ~clk;

    nsi_inverse #(.K(K), .W(W), .FRAC(FRAC), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
        .start(start), .n_terms(n_terms), .busy(busy), .done(done),
        .div_err(div_err), .out_valid(out_valid), .out_data(out_data)
    );

    int total = 0;
    int bad   = 0;
    int ra[NE];
    int stim[NE];
    int ex[NE];
    bit ex_err;
    int wp  = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog act=%0d exp<%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp_v);
        end
    endtask

    function automatic int sat(longint v);
        if (v > VMAX) return int'(VMAX);
        if (v < -VMAX - 1) return int'(-VMAX - 1);
        return int'(v);
    endfunction

    task automatic model(int nt);
        int dv[K];
        int mm[NE];
        int tt[NE];
        int tn[NE];
        int ss[NE];
        ex_err = 1'b0;
        for (int i = 0; i < K; i++) begin
            int av = ra[i*K+i];
            if (av == 0) begin
                dv[i] = 0;
                ex_err = 1'b1;
            end else begin
                longint mag = (av < 0) ? -longint'(av) : longint'(av);
                longint qv  = (longint'(1) << (2 * FRAC)) / mag;
                if (qv > VMAX) qv = VMAX;
                dv[i] = (av < 0) ? -int'(qv) : int'(qv);
            end
        end
        for (int i = 0; i < K; i++) begin
            for (int j = 0; j < K; j++) begin
                mm[i*K+j] = (i == j) ? 0 : sat((-(longint'(dv[i]) * ra[i*K+j])) >>> FRAC);
                tt[i*K+j] = (i == j) ? dv[i] : 0;
                ss[i*K+j] = tt[i*K+j];
            end
        end
        for (int n = 0; n < nt; n++) begin
            for (int i = 0; i < K; i++) begin
                for (int j = 0; j < K; j++) begin
                    longint acc = 0;
                    for (int k = 0; k < K; k++) acc += longint'(mm[i*K+k]) * tt[k*K+j];
                    tn[i*K+j] = sat(acc >>> FRAC);
                end
            end
            for (int e = 0; e < NE; e++) begin
                ss[e] = sat(longint'(ss[e]) + tn[e]);
                tt[e] = tn[e];
            end
        end
        for (int e = 0; e < NE; e++) ex[e] = ss[e];
    endtask

    task automatic gen();
        for (int i = 0; i < K; i++) begin
            for (int j = 0; j < K; j++) begin
                if (i == j) begin
                    int mg = 384 + int'($urandom % 640);
                    stim[i*K+j] = ($urandom % 2) ? -mg : mg;
                end else begin
                    stim[i*K+j] = int'($urandom % 161) - 80;
                end
            end
        end
    endtask

    task automatic load_vals(int cnt);
        for (int e = 0; e < cnt; e++) begin
            int v = (e < NE) ? stim[e] : stim[e-NE] + 7;
            @(negedge clk);
            load_valid = 1'b1;
            load_data  = W'(v);
            ra[wp]     = v;
            wp         = (wp + 1) % NE;
        end
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic run_chk(int nt, bit disturb, string req);
        int  beats = 0;
        int  dones = 0;
        int  guard = 0;
        bit  prev_done = 1'b0;
        model(nt);
        @(negedge clk);
        start   = 1'b1;
        n_terms = TW'(nt);
        wp      = 0;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 busy after start", int'(busy), 1);
        while (beats < NE && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (out_valid) begin
                if (beats == 0) chk(prev_done, "R7 done precedes first beat", int'(prev_done), 1);
                chk($signed(out_data) == ex[beats], req, int'($signed(out_data)), ex[beats]);
                beats++;
            end
            prev_done = done;
            if (done) dones++;
            if (disturb && guard == 5) begin
                start      = 1'b1;
                n_terms    = TW'((nt + 3) % 16);
                load_valid = 1'b1;
                load_data  = 16'h7fff;
            end else begin
                start      = 1'b0;
                load_valid = 1'b0;
            end
        end
        chk(dones == 1, "R7 single done pulse", dones, 1);
        chk(beats == NE, "R7 beat count", beats, NE);
        @(negedge clk);
        chk(!out_valid && !busy, "R9 idle after readout", int'(busy), 0);
        chk(div_err == ex_err, "R3 div_err after run", int'(div_err), int'(ex_err));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !out_valid && !div_err, "R9 reset state", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: identity scaled to 1.0
        for (int e = 0; e < NE; e++) stim[e] = ((e / K) == (e % K)) ? 256 : 0;
        load_vals(NE);
        run_chk(3, 1'b0, "R5 identity");

        // R4: zero term count returns the seed
        gen();
        load_vals(NE);
        run_chk(0, 1'b0, "R4 seed only");

        // R5: random dominant matrices, mixed term counts
        for (int it = 0; it < 20; it++) begin
            gen();
            load_vals(NE);
            run_chk(int'($urandom % 7), 1'b0, "R5 random");
        end

        // R3: zero diagonal entry
        gen();
        stim[2*K+2] = 0;
        load_vals(NE);
        run_chk(2, 1'b0, "R3 zero diagonal");
        gen();
        load_vals(NE);
        run_chk(1, 1'b0, "R3 err cleared by start");

        // R2 / R6: tiny diagonals saturate the reciprocal and the sums
        for (int i = 0; i < K; i++)
            for (int j = 0; j < K; j++)
                stim[i*K+j] = (i == j) ? ((i % 2) ? 2 : -3) : ((j % 2) ? -100 : 90);
        load_vals(NE);
        run_chk(2, 1'b0, "R6 saturating sum");

        // R2: most negative diagonal value
        gen();
        stim[0] = -32768;
        load_vals(NE);
        run_chk(2, 1'b0, "R2 min diagonal");

        // R1: pointer wrap overwrites the first entries
        gen();
        load_vals(NE + 3);
        run_chk(3, 1'b0, "R1 pointer wrap");

        // R8: start and load while busy are ignored
        gen();
        load_vals(NE);
        run_chk(4, 1'b1, "R8 disturb during run");
        run_chk(4, 1'b0, "R8 matrix kept after ignored load");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule